// File: doc/BRIEF.md
# Parallel ROM Read-Cycle Controller

This block lets a synchronous requester inside the chip fetch 16-bit words from an external asynchronous read-only memory of 65,536 words, addressed by word with no byte lanes. The memory is steered by two active-low lines: a chip select and an output gate. Its pins drive data only while both lines are low. With the chip select low and the gate high the outputs float. With the chip select high the part sits in low-power standby with floating outputs, whatever the other pins do.

A request carries a 16-bit word address and is taken when `req_ready` is high. The controller puts the address on the pins and lowers the chip select. It lowers the output gate only as late as the gate's own access time allows, and it samples the data pins once every access time has run out. The word comes back with a one-cycle `rsp_valid` strobe. The controller then raises the output gate and holds `req_ready` low until the float time has passed.

Each nanosecond timing becomes a cycle count at elaboration, using the clock-period parameter and rounding up. After a set number of idle cycles the chip select goes high to put the memory in standby. A read that follows soon enough keeps the chip select low and waits only for the address access time.

Top module: `prom_read_ctrl`

## Requirements
- R1: During and after reset, `rom_ce_n` and `rom_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: For a read of address A, `rsp_data` equals the memory word at A. `rsp_valid` is high for exactly one cycle per accepted request.
- R3: The data pins are sampled exactly N clock edges after the accepting edge, and `rsp_valid` rises on that same edge. When `rom_ce_n` is low at acceptance, N = ceil(T_ADDR_NS/CLK_NS)+1. When it is high, N = max(ceil(T_ADDR_NS/CLK_NS), ceil(T_CE_NS/CLK_NS))+1. The sample is never taken before the memory's data is valid.
- R4: `rom_oe_n` falls max(0, N-M) edges after the accepting edge, where M = max(1, ceil(T_OE_NS/CLK_NS)). `rom_oe_n` is never low while `rom_ce_n` is high.
- R5: On the sampling edge `rom_oe_n` returns to 1. `req_ready` stays 0 until F = max(1, ceil(T_FLOAT_NS/CLK_NS)) edges after the sampling edge, and rises on that edge.
- R6: Once `req_ready` has risen, if no request arrives, `rom_ce_n` rises exactly S = max(1, IDLE_STBY) edges later.
- R7: `rom_ce_n` stays low from the accepting edge through the float interval. A request accepted before the standby time has run out finds `rom_ce_n` still low and keeps it low.
- R8: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 on the following cycle, and `rom_addr` holds the requested address, unchanged, for the whole access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 16 | Word address of the request |
| req_ready | output | 1 | Controller can take a request this cycle |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_data` holds the read word |
| rsp_data | output | 16 | Word read from the memory |
| rom_addr | output | 16 | Address pins toward the memory |
| rom_ce_n | output | 1 | Active-low chip select toward the memory |
| rom_oe_n | output | 1 | Active-low output gate toward the memory |
| rom_data | input | 16 | Data pins from the memory |

## Verification
The assertions watch, on every cycle, the properties that need no timing reference. The output gate is never low without the chip select. The strobe lasts a single cycle and the gate is already high when it appears. The address is frozen while the controller is busy. The chip select stays low through an access. Only the bench can show that the cycle counts are right: the exact sampling edge for each starting state of the chip select, the placement of the output-gate fall, the length of the float hold-off and the standby delay. It does this with a memory model that returns poison until every access time measured from the pins has elapsed, and it flags any sample taken too early.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_SAMPLE,
    ST_FLOAT
  } rd_state_e;

  // whole cycles needed to cover t_ns, rounded up
  function automatic int cycles_up(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_cycle_timer.sv
module prom_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (step && (count != '0)) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/prom_resp_capture.sv
module prom_resp_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] pin_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) begin
        rsp_data <= pin_data;
      end
    end
  end

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/prom_read_ctrl.sv
module prom_read_ctrl
  import prom_rd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 20,
  parameter int T_ADDR_NS  = 70,
  parameter int T_CE_NS    = 70,
  parameter int T_OE_NS    = 30,
  parameter int T_FLOAT_NS = 25,
  parameter int IDLE_STBY  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  input  logic [DATA_W-1:0] rom_data
);

  // cycle counts; access counts carry one extra cycle of margin
  localparam int ADDR_CYC = cycles_up(T_ADDR_NS, CLK_NS);
  localparam int CE_CYC   = cycles_up(T_CE_NS, CLK_NS);
  localparam int ACC_ACT  = ADDR_CYC + 1;
  localparam int ACC_STBY = imax(ADDR_CYC, CE_CYC) + 1;
  localparam int OE_CYC   = imax(1, cycles_up(T_OE_NS, CLK_NS));
  localparam int FLT_CYC  = imax(1, cycles_up(T_FLOAT_NS, CLK_NS));
  localparam int STBY_CYC = imax(1, IDLE_STBY);
  localparam int MAXC     = imax(imax(ACC_STBY, OE_CYC), imax(FLT_CYC, STBY_CYC));
  localparam int CW       = $clog2(MAXC + 1);

  rd_state_e   state_q, state_d;
  logic        accept;
  logic [CW-1:0] acc_val, acc_cnt, flt_cnt, idl_cnt;
  logic        acc_step, flt_load, flt_step, flt_done, idl_step;

  always_comb begin
    accept   = (state_q == ST_IDLE) && req_valid && req_ready;
    acc_val  = rom_ce_n ? CW'(ACC_STBY - 1) : CW'(ACC_ACT - 1);
    acc_step = (state_q == ST_SETUP) || (state_q == ST_WAIT);
    flt_load = (state_q == ST_SAMPLE);
    flt_step = (state_q == ST_FLOAT);
    flt_done = (state_q == ST_FLOAT) && (flt_cnt == '0);
    idl_step = (state_q == ST_IDLE) && !accept && !rom_ce_n;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = ST_SETUP;
      ST_SETUP,
      ST_WAIT:   state_d = (acc_cnt <= CW'(1)) ? ST_SAMPLE : ST_WAIT;
      ST_SAMPLE: state_d = ST_FLOAT;
      ST_FLOAT:  if (flt_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  prom_cycle_timer #(.W(CW)) u_acc_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (acc_val),
    .step     (acc_step),
    .count    (acc_cnt)
  );

  prom_cycle_timer #(.W(CW)) u_flt_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (flt_load),
    .load_val (CW'(FLT_CYC - 1)),
    .step     (flt_step),
    .count    (flt_cnt)
  );

  prom_cycle_timer #(.W(CW)) u_idl_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (flt_done),
    .load_val (CW'(STBY_CYC)),
    .step     (idl_step),
    .count    (idl_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      req_ready <= 1'b1;
      rom_addr  <= '0;
      rom_ce_n  <= 1'b1;
      rom_oe_n  <= 1'b1;
    end else begin
      state_q   <= state_d;
      req_ready <= (state_d == ST_IDLE);
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            rom_addr <= req_addr;
            rom_ce_n <= 1'b0;
            rom_oe_n <= !(acc_val < CW'(OE_CYC));
          end else if (!rom_ce_n && (idl_cnt <= CW'(1))) begin
            rom_ce_n <= 1'b1;
          end
        end
        ST_SETUP, ST_WAIT: begin
          if (acc_cnt <= CW'(OE_CYC)) rom_oe_n <= 1'b0;
        end
        ST_SAMPLE: rom_oe_n <= 1'b1;
        default: ;
      endcase
    end
  end

  prom_resp_capture #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .capture   (state_q == ST_SAMPLE),
    .pin_data  (rom_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // R4
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_ce_n);

  // R5
  oe_off_at_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rom_oe_n && !req_ready));

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(rom_addr));

  // R7
  ce_held_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q != ST_IDLE) && !rom_ce_n) |=> !rom_ce_n);

endmodule

// File: tb/prom_read_ctrl_tb.sv
`timescale 1ns/1ps
module prom_read_ctrl_tb;

  localparam int CLK    = 20;
  localparam int TA     = 70;
  localparam int TC     = 70;
  localparam int TO     = 30;
  localparam int TF     = 25;
  localparam int STBY   = 4;
  localparam int E_ACT  = (TA + CLK - 1) / CLK + 1;
  localparam int E_STBY = ((TA > TC ? TA : TC) + CLK - 1) / CLK + 1;
  localparam int E_OE   = (TO + CLK - 1) / CLK;
  localparam int E_FLT  = (TF + CLK - 1) / CLK;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  // {address, idle gap before request, expected word}
  localparam logic [47:0] VEC [8] = '{
    {16'h0000, 16'd0, pat(16'h0000)},
    {16'hFFFF, 16'd0, pat(16'hFFFF)},
    {16'h1234, 16'd6, pat(16'h1234)},
    {16'h8001, 16'd0, pat(16'h8001)},
    {16'h00FF, 16'd1, pat(16'h00FF)},
    {16'h7FFE, 16'd5, pat(16'h7FFE)},
    {16'hAAAA, 16'd0, pat(16'hAAAA)},
    {16'h5555, 16'd3, pat(16'h5555)}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, rsp_valid, rom_ce_n, rom_oe_n;
  logic [15:0] rsp_data, rom_addr;
  logic [15:0] rom_data = 16'hDEAD;
  bit          rom_ok = 1'b0;
  bit          last_ok = 1'b0;
  int          total = 0;
  int          fails = 0;
  int          cyc = 0;

  always #10 clk = ~clk;

  prom_read_ctrl #(
    .CLK_NS(CLK), .T_ADDR_NS(TA), .T_CE_NS(TC), .T_OE_NS(TO),
    .T_FLOAT_NS(TF), .IDLE_STBY(STBY)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_data(rom_data)
  );

  // memory model: ages count whole cycles since each pin last changed
  logic [15:0] prev_addr = '0;
  logic        prev_ce = 1'b1, prev_oe = 1'b1;
  int          a_age = 0, c_age = 0, o_age = 0;
  always @(negedge clk) begin
    a_age = (rom_addr != prev_addr) ? 0 : a_age + 1;
    c_age = (rom_ce_n || prev_ce) ? 0 : c_age + 1;
    o_age = (rom_oe_n || prev_oe) ? 0 : o_age + 1;
    prev_addr = rom_addr; prev_ce = rom_ce_n; prev_oe = rom_oe_n;
    rom_ok = !rom_ce_n && !rom_oe_n && ((a_age + 1) * CLK >= TA) &&
             ((c_age + 1) * CLK >= TC) && ((o_age + 1) * CLK >= TO);
    rom_data = rom_ok ? pat(rom_addr) : 16'hDEAD;
  end

  always @(posedge clk) last_ok <= rom_ok;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a, input int gap,
                         input logic [15:0] expd, input bit b2b);
    int n, oe_at, exp_lat, exp_oe;
    bit ce_hi;
    while (!req_ready) @(negedge clk);
    repeat (gap) @(negedge clk);
    exp_lat = rom_ce_n ? E_STBY : E_ACT;
    exp_oe  = (exp_lat > E_OE) ? exp_lat - E_OE : 0;
    if (b2b) chk(!rom_ce_n, "R7 ce still low before back-to-back", rom_ce_n, 0);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    chk(rom_addr == a, "R8 address on pins", rom_addr, a);
    chk(!req_ready, "R8 ready low after accept", req_ready, 0);
    n = 0; ce_hi = 0;
    oe_at = rom_oe_n ? -1 : 0;
    while (!rsp_valid && n < 1000) begin
      @(negedge clk);
      n++;
      if (rom_ce_n) ce_hi = 1;
      if (!rom_oe_n && oe_at < 0) oe_at = n;
    end
    chk(rsp_data == expd, "R2 read data", rsp_data, expd);
    chk(n == exp_lat, "R3 sample edge", n, exp_lat);
    chk(last_ok, "R3 sampled while data valid", last_ok, 1);
    chk(oe_at == exp_oe, "R4 output gate fall", oe_at, exp_oe);
    chk(!ce_hi, "R7 ce low through access", ce_hi, 0);
    chk(rom_oe_n, "R5 gate high after sample", rom_oe_n, 1);
    chk(!req_ready, "R5 ready low at strobe", req_ready, 0);
    for (int k = 1; k <= E_FLT; k++) begin
      @(negedge clk);
      if (k == 1) chk(!rsp_valid, "R2 strobe one cycle", rsp_valid, 0);
      chk(req_ready == (k == E_FLT), "R5 float hold-off", req_ready, (k == E_FLT));
      chk(!rom_ce_n, "R7 ce low in float", rom_ce_n, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rom_ce_n, "R1 ce in reset", rom_ce_n, 1);
    chk(rom_oe_n, "R1 oe in reset", rom_oe_n, 1);
    chk(!rsp_valid, "R1 strobe in reset", rsp_valid, 0);
    chk(req_ready, "R1 ready in reset", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(rom_ce_n && rom_oe_n && req_ready && !rsp_valid, "R1 after reset", rom_ce_n, 1);

    for (int i = 0; i < 8; i++) begin
      do_read(VEC[i][47:32], int'(VEC[i][31:16]), VEC[i][15:0],
              (i > 0) && (int'(VEC[i][31:16]) == 0));
    end

    // R6 standby entry after idle time, then a read from standby
    repeat (STBY - 1) @(negedge clk);
    chk(!rom_ce_n, "R6 ce low before standby", rom_ce_n, 0);
    @(negedge clk);
    chk(rom_ce_n, "R6 ce high at standby", rom_ce_n, 1);
    do_read(16'h0F0F, 0, pat(16'h0F0F), 1'b0);

    // R8 request ignored while busy: held valid only accepted once ready
    req_valid = 1'b1; req_addr = 16'h2222;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(rom_addr == 16'h2222, "R8 first request taken", rom_addr, 16'h2222);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_data == pat(16'h2222), "R2 data after busy probe", rsp_data, pat(16'h2222));
    req_valid = 1'b1; req_addr = 16'h3333;
    @(negedge clk);
    chk(!req_ready && rom_addr == 16'h2222, "R8 no accept while busy", rom_addr, 16'h2222);
    req_valid = 1'b0;
    repeat (E_FLT + 2) @(negedge clk);
    chk(rom_addr == 16'h2222, "R8 dropped request not taken", rom_addr, 16'h2222);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(1'b0, "watchdog", cyc, 20000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule